// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block steps through the column addresses of one SDRAM burst and raises the strobes that go with each beat. A start pulse loads a start column and captures the current burst settings. The settings are the length code, the wrap order, the read latency and the single-write option. From the next cycle on, the block presents one column per clock until the burst is complete. It stops early if a stop pulse arrives, or if a newer start replaces the burst.

Reads feed a delay line, so the read-valid strobe trails each column beat by the programmed latency. Writes strobe in the same cycle as their column. Per-byte-lane mask inputs gate both strobes.

The block sits between a command decoder, which produces the start and stop pulses, and the storage array, which uses the column and the strobes. It holds no data.

Top module: `sdram_burst_seq`

## Requirements
- R1: While reset is asserted, and after reset until the first start, col_valid, rd_valid, wr_strobe, burst_done and every lane output are 0.
- R2: A start sampled at clock edge n makes col_valid 1 and col_addr equal to start_col in the cycle after edge n. Each later edge advances the burst by exactly one beat.
- R3: Length code 0, 1, 2 or 3 gives bursts of 1, 2, 4 or 8 beats. Codes 4 to 6 behave as length 1. In sequential order, beat k shows ((start_col + k) mod L) in the low log2(L) bits, and the upper bits hold start_col.
- R4: With cfg_interleave = 1 on a burst of length L up to 8, the low log2(L) bits of beat k are the start column bits XOR k, and the upper bits hold start_col.
- R5: burst_done is 1 exactly in the cycle that shows the final beat of a burst that runs to its end. col_valid is 0 in the next cycle unless a new start was sampled.
- R6: Length code 7 is a full-page burst. It is always sequential, steps over all 256 columns, wraps from 255 to 0, never raises burst_done, and runs until it is stopped or replaced.
- R7: cfg_cas_lat is 2 or 3. It is captured at each start and applies to the read delay line from then on. rd_valid for read beat k of a read started at edge n is 1 in the cycle after edge n+cfg_cas_lat-1+k.
- R8: For a write burst, wr_strobe is 1 in every cycle that shows a write beat, and rd_valid gets no beats from that write.
- R9: With cfg_single_write = 1, a write burst has exactly one beat and raises burst_done on that beat. Read bursts keep their programmed length.
- R10: burst_stop sampled at an edge, with no start at that edge, makes col_valid 0 from that edge on. Read beats already in the delay line still appear on rd_valid.
- R11: A start during an active burst replaces it at once. Read wins when rd_start and wr_start come together, and a start wins over burst_stop at the same edge.
- R12: Bit i of wr_lane_en is wr_strobe AND NOT dqm[i]. Bit i of rd_lane_oe is rd_valid AND NOT dqm[i]. Both use the dqm value of the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_burst_code | input | 3 | Burst length code (0,1,2,3 -> 1,2,4,8; 7 -> full page) |
| cfg_interleave | input | 1 | 1 selects interleaved wrap order |
| cfg_cas_lat | input | 2 | Read latency in clocks, 2 or 3 |
| cfg_single_write | input | 1 | 1 limits write bursts to one beat |
| start_col | input | 8 | First column of the burst |
| rd_start | input | 1 | Start a read burst |
| wr_start | input | 1 | Start a write burst |
| burst_stop | input | 1 | End the current burst |
| dqm | input | 2 | Per-lane mask, 1 masks the lane |
| col_addr | output | 8 | Column of the current beat |
| col_valid | output | 1 | A beat is presented this cycle |
| rd_valid | output | 1 | Read data due this cycle |
| wr_strobe | output | 1 | Write beat this cycle |
| burst_done | output | 1 | Final beat of a completed burst |
| rd_lane_oe | output | 2 | Per-lane read output enable |
| wr_lane_en | output | 2 | Per-lane write enable |

## Verification
The bench covers start columns near a block boundary in both wrap orders. A design that carried into the upper bits, or that added where it should XOR, would show a column outside the aligned block.

It also runs a full page past column 255, to catch a burst that stops or raises done at the wrap. Stops and restarts are placed in the middle of bursts and at the last beat, and some arrive while reads are still in the delay line. These cases expose a delay line that is flushed or delayed by the wrong amount.

Coincident read and write starts test the priority rule. Single-write bursts test whether a write would run its full programmed length.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
   // burst length codes on cfg_burst_code
   typedef enum logic [2:0] {
      BURST_1    = 3'd0,
      BURST_2    = 3'd1,
      BURST_4    = 3'd2,
      BURST_8    = 3'd3,
      BURST_PAGE = 3'd7
   } burst_code_t;

   localparam int unsigned MIN_CAS = 2;
endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
   import sdram_seq_pkg::*;
#(
   parameter int unsigned COL_W  = 8,
   parameter int unsigned MAX_CL = 3,
   parameter int unsigned CL_W   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       code,
   input  logic             ilv,
   input  logic [CL_W-1:0]  lat,
   input  logic             single_wr,
   input  logic [COL_W-1:0] col_in,
   input  logic             rd_go,
   input  logic             wr_go,
   input  logic             stop,
   output logic             active_q,
   output logic             is_rd_q,
   output logic [COL_W-1:0] base_q,
   output logic [COL_W-1:0] beat_q,
   output logic [COL_W-1:0] mask_q,
   output logic             ilv_q,
   output logic [CL_W-1:0]  lat_q,
   output logic             last
);
   logic             go;
   logic [COL_W-1:0] nxt_mask;
   logic             nxt_full;
   logic             full_q;
   logic [CL_W-1:0]  lat_clamp;

   assign go = rd_go | wr_go;

   always_comb begin
      nxt_mask = '0;
      nxt_full = 1'b0;
      case (burst_code_t'(code))
         BURST_2:    nxt_mask = COL_W'(1);
         BURST_4:    nxt_mask = COL_W'(3);
         BURST_8:    nxt_mask = COL_W'(7);
         BURST_PAGE: begin
            nxt_mask = '1;
            nxt_full = 1'b1;
         end
         default:    nxt_mask = '0;
      endcase
      if (!rd_go && single_wr) begin
         nxt_mask = '0;
         nxt_full = 1'b0;
      end
   end

   always_comb begin
      lat_clamp = lat;
      if (lat < CL_W'(MIN_CAS))      lat_clamp = CL_W'(MIN_CAS);
      else if (lat > CL_W'(MAX_CL))  lat_clamp = CL_W'(MAX_CL);
   end

   assign last = active_q & ~full_q & (beat_q == mask_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         is_rd_q  <= 1'b0;
         base_q   <= '0;
         beat_q   <= '0;
         mask_q   <= '0;
         full_q   <= 1'b0;
         ilv_q    <= 1'b0;
         lat_q    <= CL_W'(MIN_CAS);
      end else if (go) begin
         active_q <= 1'b1;
         is_rd_q  <= rd_go;
         base_q   <= col_in;
         beat_q   <= '0;
         mask_q   <= nxt_mask;
         full_q   <= nxt_full;
         ilv_q    <= ilv & ~nxt_full;
         lat_q    <= lat_clamp;
      end else if (stop) begin
         active_q <= 1'b0;
      end else if (active_q) begin
         if (last) active_q <= 1'b0;
         else      beat_q   <= beat_q + COL_W'(1);
      end
   end
endmodule

// File: rtl/seq_col_gen.sv
module seq_col_gen #(
   parameter int unsigned COL_W = 8
) (
   input  logic [COL_W-1:0] base,
   input  logic [COL_W-1:0] beat,
   input  logic [COL_W-1:0] mask,
   input  logic             ilv,
   output logic [COL_W-1:0] col
);
   logic [COL_W-1:0] sum;
   assign sum = base + beat;

   for (genvar i = 0; i < COL_W; i++) begin : g_bit
      // bits inside the burst block move, bits above it hold
      assign col[i] = mask[i] ? (ilv ? (base[i] ^ beat[i]) : sum[i]) : base[i];
   end
endmodule

// File: rtl/seq_lat_pipe.sv
module seq_lat_pipe #(
   parameter int unsigned MAX_CL = 3,
   parameter int unsigned CL_W   = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            beat_in,
   input  logic [CL_W-1:0] lat,
   output logic            beat_out
);
   localparam int unsigned DEPTH = MAX_CL - 1;

   logic [DEPTH-1:0] sr;

   if (DEPTH == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sr <= '0;
         else        sr <= beat_in;
      end
   end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sr <= '0;
         else        sr <= {sr[DEPTH-2:0], beat_in};
      end
   end

   always_comb begin
      beat_out = sr[0];
      for (int i = 0; i < int'(DEPTH); i++) begin
         if (lat == CL_W'(i + 2)) beat_out = sr[i];
      end
   end
endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq #(
   parameter int unsigned COL_W  = 8,
   parameter int unsigned LANES  = 2,
   parameter int unsigned MAX_CL = 3,
   parameter int unsigned CL_W   = $clog2(MAX_CL + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       cfg_burst_code,
   input  logic             cfg_interleave,
   input  logic [CL_W-1:0]  cfg_cas_lat,
   input  logic             cfg_single_write,
   input  logic [COL_W-1:0] start_col,
   input  logic             rd_start,
   input  logic             wr_start,
   input  logic             burst_stop,
   input  logic [LANES-1:0] dqm,
   output logic [COL_W-1:0] col_addr,
   output logic             col_valid,
   output logic             rd_valid,
   output logic             wr_strobe,
   output logic             burst_done,
   output logic [LANES-1:0] rd_lane_oe,
   output logic [LANES-1:0] wr_lane_en
);
   initial begin
      if (COL_W < 3)  $fatal(1, "COL_W must cover an 8-beat block");
      if (MAX_CL < 2) $fatal(1, "MAX_CL must be at least 2");
      if (LANES < 1)  $fatal(1, "LANES must be at least 1");
   end

   logic             active_q, is_rd_q, ilv_q, last;
   logic [COL_W-1:0] base_q, beat_q, mask_q;
   logic [CL_W-1:0]  lat_q;

   seq_ctrl #(.COL_W(COL_W), .MAX_CL(MAX_CL), .CL_W(CL_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .code(cfg_burst_code), .ilv(cfg_interleave),
      .lat(cfg_cas_lat), .single_wr(cfg_single_write), .col_in(start_col),
      .rd_go(rd_start), .wr_go(wr_start), .stop(burst_stop),
      .active_q(active_q), .is_rd_q(is_rd_q), .base_q(base_q), .beat_q(beat_q),
      .mask_q(mask_q), .ilv_q(ilv_q), .lat_q(lat_q), .last(last)
   );

   seq_col_gen #(.COL_W(COL_W)) u_col (
      .base(base_q), .beat(beat_q), .mask(mask_q), .ilv(ilv_q), .col(col_addr)
   );

   seq_lat_pipe #(.MAX_CL(MAX_CL), .CL_W(CL_W)) u_lat (
      .clk(clk), .rst_n(rst_n), .beat_in(active_q & is_rd_q),
      .lat(lat_q), .beat_out(rd_valid)
   );

   assign col_valid  = active_q;
   assign wr_strobe  = active_q & ~is_rd_q;
   assign burst_done = last;
   assign rd_lane_oe = {LANES{rd_valid}}  & ~dqm;
   assign wr_lane_en = {LANES{wr_strobe}} & ~dqm;
endmodule

// File: rtl/sdram_burst_seq_chk.sv
module sdram_burst_seq_chk #(
   parameter int unsigned COL_W = 8,
   parameter int unsigned LANES = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_single_write,
   input logic [COL_W-1:0] start_col,
   input logic             rd_start,
   input logic             wr_start,
   input logic             burst_stop,
   input logic [LANES-1:0] dqm,
   input logic [COL_W-1:0] col_addr,
   input logic             col_valid,
   input logic             rd_valid,
   input logic             wr_strobe,
   input logic             burst_done,
   input logic [LANES-1:0] rd_lane_oe,
   input logic [LANES-1:0] wr_lane_en
);
   p_start_col_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_start || wr_start) |=> (col_valid && col_addr == $past(start_col)));

   p_done_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
      burst_done |-> col_valid);

   p_single_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_start && !rd_start && cfg_single_write) |=> (burst_done && wr_strobe));

   p_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_stop && !rd_start && !wr_start) |=> !col_valid);

   p_rd_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_start && wr_start) |=> !wr_strobe);

   p_wr_mask_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (|wr_lane_en) |-> (wr_strobe && ((wr_lane_en & dqm) == '0)));

   p_rd_mask_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (|rd_lane_oe) |-> (rd_valid && ((rd_lane_oe & dqm) == '0)));
endmodule

bind sdram_burst_seq sdram_burst_seq_chk #(.COL_W(COL_W), .LANES(LANES)) u_chk (.*);

// File: tb/sim_sdram_burst_seq.sv
module sim_sdram_burst_seq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] cfg_burst_code = 3'd0;
   logic       cfg_interleave = 1'b0;
   logic [1:0] cfg_cas_lat = 2'd2;
   logic       cfg_single_write = 1'b0;
   logic [7:0] start_col = 8'd0;
   logic       rd_start = 1'b0, wr_start = 1'b0, burst_stop = 1'b0;
   logic [1:0] dqm = 2'b00;
   logic [7:0] col_addr;
   logic       col_valid, rd_valid, wr_strobe, burst_done;
   logic [1:0] rd_lane_oe, wr_lane_en;

   int checks = 0, errors = 0;
   bit done_flag = 0;

   always #4 clk = ~clk;

   sdram_burst_seq u0 (.*);

   // reference model built from the requirements
   int m_active = 0, m_rd = 0, m_k = 0, m_mask = 0, m_full = 0, m_ilv = 0, m_lat = 2, m_sw = 0;
   int m_base = 0;
   logic [1:0] m_p = 2'b00;

   function automatic int len_mask(input logic [2:0] c);
      case (c)
         3'd1: return 1;
         3'd2: return 3;
         3'd3: return 7;
         3'd7: return 255;
         default: return 0;
      endcase
   endfunction

   function automatic int exp_col(input int b, input int k, input int msk, input int il);
      int low;
      if (il != 0) low = (b ^ k) & msk;
      else         low = (b + k) & msk;
      return (b & ~msk & 255) | low;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_active = 0; m_rd = 0; m_k = 0; m_p = 2'b00;
      end else begin
         int lst;
         lst = (m_active != 0 && m_full == 0 && m_k == m_mask) ? 1 : 0;
         m_p = {m_p[0], (m_active != 0 && m_rd != 0)};
         if (rd_start || wr_start) begin
            m_active = 1; m_rd = rd_start ? 1 : 0; m_k = 0; m_base = int'(start_col);
            m_mask = len_mask(cfg_burst_code);
            m_full = (cfg_burst_code == 3'd7) ? 1 : 0;
            m_sw = (!rd_start && cfg_single_write) ? 1 : 0;
            if (m_sw != 0) begin m_mask = 0; m_full = 0; end
            m_ilv = (cfg_interleave && m_full == 0) ? 1 : 0;
            m_lat = (cfg_cas_lat == 2'd3) ? 3 : 2;
         end else if (burst_stop) begin
            m_active = 0;
         end else if (m_active != 0) begin
            if (lst != 0) m_active = 0;
            else m_k = (m_k + 1) % 256;
         end
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic compare();
      int er, ew;
      er = (m_lat == 3) ? int'(m_p[1]) : int'(m_p[0]);
      ew = (m_active != 0 && m_rd == 0) ? 1 : 0;
      chk("R2 col_valid", int'(col_valid), m_active);
      if (m_active != 0) begin
         if (m_full != 0)     chk("R6 full-page column", int'(col_addr), exp_col(m_base, m_k, m_mask, 0));
         else if (m_ilv != 0) chk("R4 interleaved column", int'(col_addr), exp_col(m_base, m_k, m_mask, 1));
         else                 chk("R3 sequential column", int'(col_addr), exp_col(m_base, m_k, m_mask, 0));
      end
      chk("R7 rd_valid", int'(rd_valid), er);
      if (m_sw != 0) chk("R9 single-write strobe", int'(wr_strobe), ew);
      else           chk("R8 wr_strobe", int'(wr_strobe), ew);
      chk("R5 burst_done", int'(burst_done),
          (m_active != 0 && m_full == 0 && m_k == m_mask) ? 1 : 0);
      chk("R12 lane enables", int'({rd_lane_oe, wr_lane_en}),
          int'({(er != 0 ? ~dqm : 2'b00), (ew != 0 ? ~dqm : 2'b00)}));
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      compare();
   endtask

   task automatic cfg(input logic [2:0] c, input logic il, input logic [1:0] cl, input logic sw);
      cfg_burst_code = c; cfg_interleave = il; cfg_cas_lat = cl; cfg_single_write = sw;
   endtask

   task automatic launch(input logic rd, input logic wr, input logic [7:0] col);
      start_col = col; rd_start = rd; wr_start = wr;
      step();
      rd_start = 0; wr_start = 0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         dqm = 2'($urandom);
         step();
      end
   endtask

   initial begin
      #(8 * 150000);
      if (!done_flag) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 col_valid in reset", int'(col_valid), 0);
      chk("R1 rd_valid in reset", int'(rd_valid), 0);
      chk("R1 wr_strobe in reset", int'(wr_strobe), 0);
      chk("R1 lanes in reset", int'({rd_lane_oe, wr_lane_en}), 0);
      rst_n = 1'b1;
      idle(2);
      chk("R1 burst_done idle", int'(burst_done), 0);

      // directed: sequential BL8 near block end, CL3 read
      cfg(3'd3, 1'b0, 2'd3, 1'b0);
      launch(1, 0, 8'h2E);
      chk("R2 first column", int'(col_addr), 8'h2E);
      idle(12);
      // interleaved BL8 write
      cfg(3'd3, 1'b1, 2'd2, 1'b0);
      launch(0, 1, 8'h95);
      idle(10);
      // BL4 interleave read CL2
      cfg(3'd2, 1'b1, 2'd2, 1'b0);
      launch(1, 0, 8'hF3);
      idle(6);
      // single write with BL8, then read still 8 beats
      cfg(3'd3, 1'b0, 2'd2, 1'b1);
      launch(0, 1, 8'h41);
      chk("R9 single-write done", int'(burst_done), 1);
      idle(2);
      launch(1, 0, 8'h41);
      idle(10);
      // full page across wrap, then stop
      cfg(3'd7, 1'b1, 2'd3, 1'b0);
      launch(1, 0, 8'hFA);
      idle(262);
      chk("R6 page still running", int'(col_valid), 1);
      burst_stop = 1; step(); burst_stop = 0;
      chk("R10 stop ends beats", int'(col_valid), 0);
      idle(4);
      // restart mid burst; rd/wr together; start over stop
      cfg(3'd3, 1'b0, 2'd3, 1'b0);
      launch(1, 0, 8'h10);
      idle(2);
      launch(0, 1, 8'h77);
      chk("R11 restart column", int'(col_addr), 8'h77);
      idle(1);
      launch(1, 1, 8'h08);
      chk("R11 read priority", int'(wr_strobe), 0);
      burst_stop = 1;
      launch(0, 1, 8'h33);
      burst_stop = 0;
      chk("R11 start beats stop", int'(col_valid), 1);
      idle(10);

      // constrained random
      for (int b = 0; b < 400; b++) begin
         logic [2:0] c;
         int r;
         r = $urandom_range(0, 9);
         c = (r < 8) ? 3'(r % 4) : ((r == 8) ? 3'd7 : 3'(4 + $urandom_range(0, 2)));
         cfg(c, 1'($urandom), ($urandom_range(0, 1) != 0) ? 2'd3 : 2'd2, 1'($urandom));
         dqm = 2'($urandom);
         r = $urandom_range(0, 3);
         launch(r != 0, r == 0 || r == 3, 8'($urandom));
         for (int i = 0; i < $urandom_range(0, 12); i++) begin
            dqm = 2'($urandom);
            burst_stop = ($urandom_range(0, 15) == 0);
            step();
            burst_stop = 0;
         end
      end
      idle(6);

      done_flag = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule